// File: doc/BRIEF.md
# Configuration Space Register Unit

This unit holds a bus agent's 256-byte configuration space and answers configuration read and configuration write cycles on a shared parallel bus. It does not use the address to decide whether a cycle is its own. It claims a cycle when three things are true in the address phase: its dedicated select line is high, the two lowest address/data bits mark a type 0 access, and the command is a configuration read or a configuration write. It latches the dword index from address bits 7:2. It asserts its claim signal one cycle later and its ready signal one cycle after that. It then completes the single data phase once the initiator signals ready.

The space holds fixed identity words (vendor/device, class/revision, and a status half-word with a 66 MHz-capable flag). It also holds a command register with a small set of writable bits, one sizable memory base address register and an interrupt line register beside a fixed interrupt pin value. A small user-defined scratch area sits at 40h. Writes are applied byte lane by byte lane under active-low byte enables. The memory-enable command bit and the decoded base address are exported to the neighbouring target responder.

Top module: `cfg_space_unit`

## Requirements
- R1: While reset is active, and after it is released, claimN and readyN are high, adOe is 0, memEn is 0 and barBase is 0.
- R2: A cycle is claimed only when three conditions hold on the first clock with frameN low after frameN was high: idsel is 1, adIn[1:0] is 00, and cbeN is 4'b1010 (read) or 4'b1011 (write). devselN falls one cycle after that address clock and trdyN falls one cycle after devselN. Any other cycle is never claimed and changes no register.
- R3: A read returns {DEVICE_ID, VENDOR_ID} at 00h, {status, command} at 04h with status bit 5 equal to FAST66, and CLASS_REV at 08h. adOut is driven (adOe=1) only while trdyN is low in a read.
- R4: Command register bits 0, 1, 2, 6 and 8 are writable. All other command bits read 0. memEn follows command bit 1.
- R5: In the base address register at 10h, bits below BAR_SIZE_LOG2 read 0 and ignore writes. This makes bits 3:0 read 0 (memory, 32-bit, non-prefetchable). Writing all ones reads back ~(2**BAR_SIZE_LOG2 - 1).
- R6: A write updates only byte lanes whose cbeN bit is 0. cbeN[k] guards adIn[8k+7:8k].
- R7: At 3Ch, bits 7:0 are a writable interrupt line and bits 15:8 read INT_PIN. The upper half reads 0.
- R8: USER_WORDS dwords from 40h upward are fully writable. Every other offset reads 0 and ignores writes.
- R9: While trdyN is low, the data phase waits until irdyN is low. On the clock where both are low the transfer happens, and on the next cycle devselN and trdyN are high again. A new address phase may begin on that very cycle.
- R10: barBase equals the base address register value, and memEn and barBase take a written value on the cycle after the transfer clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| frameN | input | 1 | Transaction framing from the initiator, active low |
| irdyN | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Dedicated configuration select, active high |
| adIn | input | 32 | Address/data bus as received |
| cbeN | input | 4 | Command in the address phase, byte enables (active low) in the data phase |
| adOut | output | 32 | Read data, zero when not driving |
| adOe | output | 1 | Output enable for adOut |
| devselN | output | 1 | Claim signal, active low |
| trdyN | output | 1 | Target ready, active low |
| memEn | output | 1 | Memory decode enable for the target responder |
| barBase | output | 32 | Decoded memory base for the target responder |

## Verification
Two functions can fall in the same cycle: the retirement of one access and the address phase of the next. The bench provokes this by starting a new configuration cycle on the clock right after a transfer, with no idle cycle between. It judges the result by the claim latency of the second access and by the data the second access reads back, which must already reflect the first access's write. Random accesses mix in wrong select, wrong type and wrong command, and read-wait states, all against a bench reference model of the register file.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;
  localparam logic [1:0] TYPE0      = 2'b00;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;   // address phase accepted: capture dword index
    logic commit;  // write transfer on this edge
    logic drive;   // read data phase: put data on the bus
  } cfgStrb_t;
endpackage

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic       irdyN,
  input  logic       idsel,
  input  logic [1:0] adLow,
  input  logic [3:0] cbeN,
  output logic       devselN,
  output logic       trdyN,
  output cfgStrb_t   strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_CLAIM, ST_DATA} ctlState_t;

  ctlState_t state;
  logic prevFrameN;
  logic isWrite;
  logic cmdOk;
  logic addrHit;

  assign cmdOk   = (cbeN == CMD_CFG_RD) || (cbeN == CMD_CFG_WR);
  assign addrHit = (state == ST_IDLE) && !frameN && prevFrameN &&
                   idsel && (adLow == TYPE0) && cmdOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      prevFrameN <= 1'b1;
      isWrite    <= 1'b0;
    end else begin
      prevFrameN <= frameN;
      case (state)
        ST_IDLE: if (addrHit) begin
          state   <= ST_CLAIM;
          isWrite <= cbeN[0];
        end
        ST_CLAIM: state <= ST_DATA;
        ST_DATA:  if (!irdyN) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign devselN     = (state == ST_IDLE);
  assign trdyN       = (state != ST_DATA);
  assign strb.latch  = addrHit;
  assign strb.commit = (state == ST_DATA) && !irdyN && isWrite;
  assign strb.drive  = (state == ST_DATA) && !isWrite;

  // R2: ready never without claim
  assert_ready_needs_claim_R2: assert property (@(posedge clk) disable iff (!rstN)
    !trdyN |-> !devselN);
  // R2: ready follows claim by one cycle
  assert_ready_after_claim_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(devselN) |=> !trdyN);
  // R9: target holds ready while the initiator waits
  assert_hold_on_wait_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!trdyN && irdyN) |=> !trdyN);
  // R9: release after the transfer
  assert_release_after_xfer_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!trdyN && !irdyN) |=> (devselN && trdyN));
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'h1D5A,
  parameter logic [15:0] DEVICE_ID     = 16'h7013,
  parameter logic [31:0] CLASS_REV     = 32'h0580_0002,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter bit          FAST66        = 1'b1,
  parameter int          BAR_SIZE_LOG2 = 12,
  parameter int          USER_WORDS    = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  cfgStrb_t    strb,
  input  logic [31:0] adIn,
  input  logic [3:0]  cbeN,
  output logic [31:0] rdData,
  output logic        memEn,
  output logic [31:0] barBase
);
  localparam logic [15:0] CMD_MASK   = 16'h0147;
  localparam logic [15:0] STATUS_VAL = 16'(FAST66) << 5;
  localparam logic [31:0] BAR_MASK   = ~((32'd1 << BAR_SIZE_LOG2) - 32'd1);
  localparam int          USER_BASE  = 16;
  localparam logic [5:0]  IDX_CMD    = 6'd1;
  localparam logic [5:0]  IDX_BAR    = 6'd4;
  localparam logic [5:0]  IDX_INT    = 6'd15;

  logic [5:0]  dwIdx;
  logic [31:0] laneMask;
  logic [15:0] cmdReg;
  logic [31:0] barReg;
  logic [7:0]  intLine;
  logic [31:0] userWords [USER_WORDS];

  assign laneMask = {{8{~cbeN[3]}}, {8{~cbeN[2]}}, {8{~cbeN[1]}}, {8{~cbeN[0]}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dwIdx <= '0;
    else if (strb.latch) dwIdx <= adIn[7:2];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg  <= '0;
      barReg  <= '0;
      intLine <= '0;
    end else if (strb.commit) begin
      if (dwIdx == IDX_CMD)
        cmdReg <= (cmdReg & ~(laneMask[15:0] & CMD_MASK)) |
                  (adIn[15:0] & laneMask[15:0] & CMD_MASK);
      if (dwIdx == IDX_BAR)
        barReg <= (barReg & ~(laneMask & BAR_MASK)) | (adIn & laneMask & BAR_MASK);
      if (dwIdx == IDX_INT)
        intLine <= (intLine & ~laneMask[7:0]) | (adIn[7:0] & laneMask[7:0]);
    end
  end

  for (genvar gi = 0; gi < USER_WORDS; gi++) begin : g_user
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) userWords[gi] <= '0;
      else if (strb.commit && dwIdx == 6'(USER_BASE + gi))
        userWords[gi] <= (userWords[gi] & ~laneMask) | (adIn & laneMask);
    end
  end

  always_comb begin
    rdData = '0;
    case (dwIdx)
      6'd0:    rdData = {DEVICE_ID, VENDOR_ID};
      IDX_CMD: rdData = {STATUS_VAL, cmdReg};
      6'd2:    rdData = CLASS_REV;
      IDX_BAR: rdData = barReg;
      IDX_INT: rdData = {16'h0, INT_PIN, intLine};
      default: rdData = '0;
    endcase
    for (int i = 0; i < USER_WORDS; i++)
      if (dwIdx == 6'(USER_BASE + i)) rdData = userWords[i];
  end

  assign memEn   = cmdReg[1];
  assign barBase = barReg;

  // R4: command register moves only on a write transfer
  assert_cmd_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(cmdReg));
  // R7: interrupt line moves only on a write transfer
  assert_intline_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(intLine));
  // R5: base register moves only on a write transfer
  assert_bar_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(barReg));
endmodule

// File: rtl/cfg_space_unit.sv
module cfg_space_unit
  import cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'h1D5A,
  parameter logic [15:0] DEVICE_ID     = 16'h7013,
  parameter logic [31:0] CLASS_REV     = 32'h0580_0002,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter bit          FAST66        = 1'b1,
  parameter int          BAR_SIZE_LOG2 = 12,
  parameter int          USER_WORDS    = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameN,
  input  logic        irdyN,
  input  logic        idsel,
  input  logic [31:0] adIn,
  input  logic [3:0]  cbeN,
  output logic [31:0] adOut,
  output logic        adOe,
  output logic        devselN,
  output logic        trdyN,
  output logic        memEn,
  output logic [31:0] barBase
);
  cfgStrb_t    strb;
  logic [31:0] rdData;

  cfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .idsel(idsel),
    .adLow(adIn[1:0]), .cbeN(cbeN), .devselN(devselN), .trdyN(trdyN), .strb(strb)
  );

  cfg_regs #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .CLASS_REV(CLASS_REV),
    .INT_PIN(INT_PIN), .FAST66(FAST66), .BAR_SIZE_LOG2(BAR_SIZE_LOG2),
    .USER_WORDS(USER_WORDS)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .adIn(adIn), .cbeN(cbeN),
    .rdData(rdData), .memEn(memEn), .barBase(barBase)
  );

  assign adOe  = strb.drive;
  assign adOut = strb.drive ? rdData : 32'h0;
endmodule

// File: tb/cfg_space_unit_test.sv
`timescale 1ns/1ps
module cfg_space_unit_test;
  localparam logic [15:0] VEN = 16'h1D5A;
  localparam logic [15:0] DEV = 16'h7013;
  localparam logic [31:0] CRV = 32'h0580_0002;
  localparam logic [7:0]  IPIN = 8'h01;
  localparam int          SZ = 12;
  localparam int          UW = 4;
  localparam logic [15:0] CMASK = 16'h0147;
  localparam logic [31:0] BMASK = 32'hFFFF_F000;

  logic clk = 0, rstN = 0, frameN = 1, irdyN = 1, idsel = 0;
  logic [31:0] adIn = 0;
  logic [3:0]  cbeN = 4'hF;
  logic [31:0] adOut, barBase;
  logic adOe, devselN, trdyN, memEn;
  int total = 0, bad = 0;

  logic [15:0] mCmd;
  logic [31:0] mBar;
  logic [7:0]  mInt;
  logic [31:0] mUser [UW];

  always #2.5 clk = ~clk;

  cfg_space_unit #(.VENDOR_ID(VEN), .DEVICE_ID(DEV), .CLASS_REV(CRV), .INT_PIN(IPIN),
    .FAST66(1'b1), .BAR_SIZE_LOG2(SZ), .USER_WORDS(UW)) uut (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .idsel(idsel),
    .adIn(adIn), .cbeN(cbeN), .adOut(adOut), .adOe(adOe), .devselN(devselN),
    .trdyN(trdyN), .memEn(memEn), .barBase(barBase));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lanes(input logic [3:0] be);
    return {{8{~be[3]}}, {8{~be[2]}}, {8{~be[1]}}, {8{~be[0]}}};
  endfunction

  function automatic logic [31:0] expRead(input logic [7:0] off);
    logic [5:0] ix = off[7:2];
    if (ix == 0) return {DEV, VEN};
    if (ix == 1) return {16'h0020, mCmd};
    if (ix == 2) return CRV;
    if (ix == 4) return mBar;
    if (ix == 15) return {16'h0, IPIN, mInt};
    if (ix >= 16 && ix < 16 + UW) return mUser[ix - 16];
    return 32'h0;
  endfunction

  task automatic modelWrite(input logic [7:0] off, input logic [31:0] wd, input logic [3:0] be);
    logic [31:0] m = lanes(be);
    logic [5:0] ix = off[7:2];
    if (ix == 1) mCmd = (mCmd & ~(m[15:0] & CMASK)) | (wd[15:0] & m[15:0] & CMASK);
    if (ix == 4) mBar = (mBar & ~(m & BMASK)) | (wd & m & BMASK);
    if (ix == 15) mInt = (mInt & ~m[7:0]) | (wd[7:0] & m[7:0]);
    if (ix >= 16 && ix < 16 + UW) mUser[ix - 16] = (mUser[ix - 16] & ~m) | (wd & m);
  endtask

  // Starts at a negedge, ends at the negedge after the transfer with the bus idle.
  task automatic access(input bit wr, input bit sel, input logic [1:0] typ, input logic [3:0] cmd,
                        input logic [7:0] off, input logic [31:0] wd, input logic [3:0] be,
                        input int waits);
    bit expClaim, claimed, done;
    int devLat, trdyLat;
    logic [31:0] rd;
    expClaim = sel && typ == 2'b00 && (cmd == 4'b1010 || cmd == 4'b1011);
    frameN = 0; irdyN = 1; idsel = sel; adIn = {24'h0, off[7:2], typ}; cbeN = cmd;
    @(negedge clk);
    idsel = 0; cbeN = be; adIn = wr ? wd : 32'h0;
    devLat = -1; trdyLat = -1; claimed = 0; done = 0; rd = 0;
    for (int c = 1; c <= 10 && !done; c++) begin
      if (!devselN && devLat < 0) devLat = c;
      if (!trdyN && trdyLat < 0) trdyLat = c;
      if (c == 1) check(!adOe, "R3 turnaround no drive", 32'(adOe), 0);
      if (c > waits) begin irdyN = 0; frameN = 1; end
      if (!irdyN && !trdyN) begin
        rd = adOut; claimed = 1; done = 1;
        if (!wr) check(adOe, "R3 drive during read data", 32'(adOe), 1);
      end
      @(negedge clk);
    end
    frameN = 1; irdyN = 1; adIn = 0; cbeN = 4'hF;
    check(claimed == expClaim, "R2 claim decision", 32'(claimed), 32'(expClaim));
    if (expClaim) begin
      check(devLat == 1, "R2 claim latency", 32'(devLat), 1);
      check(trdyLat == 2, "R2 ready latency", 32'(trdyLat), 2);
      check(devselN && trdyN, "R9 release after transfer", {devselN, trdyN}, 2'b11);
      if (wr) modelWrite(off, wd, be);
      else check(rd === expRead(off), "R3 R8 read data", rd, expRead(off));
      check(memEn == mCmd[1], "R4 R10 memEn", 32'(memEn), 32'(mCmd[1]));
      check(barBase == mBar, "R10 barBase", barBase, mBar);
    end
  endtask

  task automatic rd(input logic [7:0] off); access(0, 1, 2'b00, 4'b1010, off, 0, 4'h0, 0); endtask
  task automatic wr(input logic [7:0] off, input logic [31:0] d, input logic [3:0] be);
    access(1, 1, 2'b00, 4'b1011, off, d, be, 0);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mCmd = 0; mBar = 0; mInt = 0;
    for (int i = 0; i < UW; i++) mUser[i] = 0;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    // R1 during reset
    check(devselN && trdyN && !adOe, "R1 handshake in reset", {devselN, trdyN, adOe}, 3'b110);
    check(!memEn && barBase == 0, "R1 exports in reset", barBase, 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    check(devselN && trdyN && !adOe && !memEn, "R1 after release", {devselN, trdyN, adOe, memEn}, 4'b1100);
    // identity R3
    rd(8'h00); rd(8'h04); rd(8'h08); rd(8'h0C);
    // R4 command bits
    wr(8'h04, 32'hFFFF_FFFF, 4'h0); rd(8'h04);
    check(memEn == 1, "R4 memEn set", 32'(memEn), 1);
    wr(8'h04, 32'h0000_0000, 4'hE); rd(8'h04);
    // R5 sizing
    wr(8'h10, 32'hFFFF_FFFF, 4'h0); rd(8'h10);
    check(barBase == 32'hFFFF_F000, "R5 sizing readback", barBase, 32'hFFFF_F000);
    wr(8'h10, 32'hA5A5_A5AF, 4'h0); rd(8'h10);
    // R6 partial lanes on user word
    wr(8'h40, 32'h1122_3344, 4'h0); wr(8'h40, 32'hAABB_CCDD, 4'b1010); rd(8'h40);
    // R7 interrupt line/pin
    wr(8'h3C, 32'hFFFF_FF5C, 4'h0); rd(8'h3C);
    // R8 unimplemented offsets
    wr(8'h14, 32'hFFFF_FFFF, 4'h0); rd(8'h14); wr(8'hFC, 32'hDEAD_BEEF, 4'h0); rd(8'hFC);
    // R2 ignored cycles: no select, type 1, memory command
    access(1, 0, 2'b00, 4'b1011, 8'h3C, 32'h0000_0011, 4'h0, 0);
    access(1, 1, 2'b01, 4'b1011, 8'h3C, 32'h0000_0022, 4'h0, 0);
    access(1, 1, 2'b00, 4'b0111, 8'h3C, 32'h0000_0033, 4'h0, 0);
    rd(8'h3C);
    // R9 initiator wait states on read and write
    access(0, 1, 2'b00, 4'b1010, 8'h44, 0, 4'h0, 3);
    access(1, 1, 2'b00, 4'b1011, 8'h44, 32'h600D_F00D, 4'h0, 2);
    rd(8'h44);
    // R9 back-to-back: write retires, next address phase the very next cycle
    wr(8'h48, 32'h0BAD_CAFE, 4'h0);
    rd(8'h48);
    wr(8'h04, 32'h0000_0002, 4'h0);
    rd(8'h04);
    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [7:0] off;
      bit w, s;
      logic [1:0] t;
      logic [3:0] cm;
      off = ($urandom_range(0, 9) == 0) ? 8'($urandom_range(0, 255)) : 8'($urandom_range(0, 23) * 4);
      w = 1'($urandom_range(0, 1));
      s = ($urandom_range(0, 7) != 0);
      t = ($urandom_range(0, 7) == 0) ? 2'b01 : 2'b00;
      cm = ($urandom_range(0, 7) == 0) ? 4'b0110 : (w ? 4'b1011 : 4'b1010);
      access(w, s, t, cm, off, $urandom, 4'($urandom_range(0, 15)), $urandom_range(0, 2));
      if ($urandom_range(0, 1) == 1) @(negedge clk);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule